// File: doc/BRIEF.md
# UART Transmitter with Break Control

This block is the transmit half of an asynchronous serial port. Software reaches it through a byte-wide register bus with address, write data, a write strobe and a read strobe. Bytes written to the data address queue in a transmit FIFO, or in a single holding register when the FIFO is switched off. A serialiser then frames each byte with a start bit, 5 to 8 data bits sent LSB first, an optional parity bit and one or two stop bits. The bit rate comes from a 16-bit divisor followed by a fixed divide-by-16. The two divisor bytes appear at the two lowest addresses while a divisor-access bit in the line-control register is set.

Two line-control bits exist to exercise a far-end receiver. One holds the line low (break). Break takes effect only on a bit boundary and drops the frame in flight. Setting it empties the queue. The other bit inverts the parity bit of every frame. The bus has no back-pressure: a write to the data address when the queue is full is dropped. Software should watch the transmit-empty flag before writing.

Top module: `uart_break_tx`

## Requirements
- R1: While line-control bit 7 is 1, address 0 and address 1 write and read the divisor low and high bytes. While it is 0, a write to address 0 queues a byte and reads of addresses 0 and 1 return 0.
- R2: A frame is one start bit of 0, then data bits LSB first, with the count set by line-control bits [1:0] (0..3 select 5..8 bits). An optional parity bit follows when bit 3 is 1; bit 4 = 1 selects even parity and 0 selects odd. Then come one stop bit of 1, or two when bit 2 is 1. The line idles at 1, and queued bytes go out back to back.
- R3: A non-zero divisor D gives a bit period of 16*D clocks. A divisor of 0 stops the bit clock, and the line and queue stay frozen.
- R4: Once line-control bit 6 (break) is 1, the line goes to 0 at the next bit boundary and stays there. The frame in the shift register is abandoned.
- R5: A write that sets the break bit while it was 0 empties the queue in the same cycle.
- R6: After the break bit is cleared, the line returns to 1 at the next bit boundary. Bytes written during the break are kept and sent after that boundary.
- R7: When line-control bits 5 and 3 are both 1, the transmitted parity bit is the inverse of the correct one.
- R8: Address 2 bit 0 enables the FIFO (DEPTH entries). When it is 0, only one byte is held and further writes are dropped. Any write to address 2 empties the queue.
- R9: The line-control register at address 3 resets to 0 and reads back as written. Read data is registered and valid the cycle after the read strobe.
- R10: The tx_empty output, also readable at address 5 bit 0, is 1 exactly when no byte is waiting in the queue.
- R11: The serial output changes only on a bit boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, registered |
| tx_empty | output | 1 | High when the transmit queue is empty |
| txd | output | 1 | Serial transmit line |

## Verification
Any slip in the bit counter, the queue pointers or the break state shows on txd within one bit period. It appears as a bit of the wrong value or length, a missing or extra frame, or a line that leaves break in mid-bit. A wrong queue count shows on tx_empty in the cycle after the access that caused it. The bench therefore compares txd and tx_empty against a behavioural model on every clock, and so catches a divergence in the first cycle it appears.

// File: rtl/uart_break_tx_pkg.sv
package uart_break_tx_pkg;
  localparam int DIV_W    = 16;
  localparam int OVS      = 16;
  localparam int FRAME_W  = 12;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_DIVH = 3'd1;
  localparam logic [2:0] A_FCTL = 3'd2;
  localparam logic [2:0] A_LCTL = 3'd3;
  localparam logic [2:0] A_STAT = 3'd5;

  typedef struct packed {
    logic       div_access;
    logic       brk;
    logic       bad_par;
    logic       even;
    logic       par_en;
    logic       two_stop;
    logic [1:0] wlen;
  } lctl_t;
endpackage

// File: rtl/uart_break_tx_baud.sv
module uart_break_tx_baud #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             bit_tick
);
  localparam int SUB_W = $clog2(OVS);

  logic [DIV_W-1:0] cnt;
  logic [SUB_W-1:0] sub;
  logic             run, sub_end;

  assign run      = (divisor != '0);
  assign sub_end  = run && (cnt >= divisor - 1'b1);
  assign bit_tick = sub_end && (sub == SUB_W'(OVS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      sub <= '0;
    end else if (sub_end) begin
      cnt <= '0;
      sub <= (sub == SUB_W'(OVS - 1)) ? '0 : sub + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_break_tx_fifo.sv
module uart_break_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       single,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [$clog2(DEPTH+1)-1:0] cap
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign cap     = single ? CW'(1) : CW'(DEPTH);
  assign push_ok = push && (count < cap);
  assign pop_ok  = pop && (count != '0);
  assign empty   = (count == '0);
  assign head    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/uart_break_tx_shift.sv
module uart_break_tx_shift
  import uart_break_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       brk_req,
  input  logic [1:0] wlen,
  input  logic       two_stop,
  input  logic       par_en,
  input  logic       even,
  input  logic       bad_par,
  input  logic       q_empty,
  input  logic [7:0] q_head,
  output logic       pop,
  output logic       brk_act,
  output logic       txd
);
  logic [FRAME_W-1:0] shreg, frame;
  logic [3:0]         remain, nbits;
  logic [7:0]         dmask;
  logic               par;
  int                 nd;

  always_comb begin
    nd    = 5 + int'(wlen);
    dmask = q_head & (8'hFF >> (3 - int'(wlen)));
    par   = (^dmask) ^ ~even ^ bad_par;
    frame = '1;
    for (int i = 0; i < 8; i++)
      if (i < nd) frame[i] = dmask[i];
    for (int i = 5; i < 9; i++)
      if (par_en && i == nd) frame[i] = par;
    nbits = 4'(nd) + 4'(par_en) + (two_stop ? 4'd2 : 4'd1);
  end

  assign pop = bit_tick && !brk_req && !brk_act && (remain == '0) && !q_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txd     <= 1'b1;
      brk_act <= 1'b0;
      remain  <= '0;
      shreg   <= '1;
    end else if (bit_tick) begin
      if (brk_req) begin
        brk_act <= 1'b1;
        txd     <= 1'b0;
        remain  <= '0;
      end else if (brk_act) begin
        brk_act <= 1'b0;
        txd     <= 1'b1;
      end else if (remain != '0) begin
        txd    <= shreg[0];
        shreg  <= {1'b1, shreg[FRAME_W-1:1]};
        remain <= remain - 1'b1;
      end else if (!q_empty) begin
        txd    <= 1'b0;
        shreg  <= frame;
        remain <= nbits;
      end else begin
        txd <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_break_tx.sv
module uart_break_tx
  import uart_break_tx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  output logic       tx_empty,
  output logic       txd
);
  localparam int CW = $clog2(DEPTH + 1);

  lctl_t            lctl;
  logic [DIV_W-1:0] divisor;
  logic             fifo_en;
  logic             bit_tick, push, pop, q_clear, brk_act;
  logic [7:0]       q_head;
  logic [CW-1:0]    q_count, q_cap;

  assign push    = bus_wr && bus_addr == A_DATA && !lctl.div_access;
  assign q_clear = bus_wr && ((bus_addr == A_FCTL) ||
                   (bus_addr == A_LCTL && bus_wdata[6] && !lctl.brk));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lctl    <= '0;
      divisor <= '0;
      fifo_en <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DATA: if (lctl.div_access) divisor[7:0]  <= bus_wdata;
        A_DIVH: if (lctl.div_access) divisor[15:8] <= bus_wdata;
        A_FCTL: fifo_en <= bus_wdata[0];
        A_LCTL: lctl    <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_DATA:  bus_rdata <= lctl.div_access ? divisor[7:0]  : 8'h00;
        A_DIVH:  bus_rdata <= lctl.div_access ? divisor[15:8] : 8'h00;
        A_FCTL:  bus_rdata <= {7'b0, fifo_en};
        A_LCTL:  bus_rdata <= lctl;
        A_STAT:  bus_rdata <= {7'b0, tx_empty};
        default: bus_rdata <= 8'h00;
      endcase
    end
  end

  uart_break_tx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .bit_tick(bit_tick)
  );

  uart_break_tx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(q_clear), .single(!fifo_en),
    .push(push), .wdata(bus_wdata), .pop(pop), .head(q_head),
    .empty(tx_empty), .count(q_count), .cap(q_cap)
  );

  uart_break_tx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .brk_req(lctl.brk),
    .wlen(lctl.wlen), .two_stop(lctl.two_stop), .par_en(lctl.par_en),
    .even(lctl.even), .bad_par(lctl.bad_par), .q_empty(tx_empty),
    .q_head(q_head), .pop(pop), .brk_act(brk_act), .txd(txd)
  );
endmodule

// File: rtl/uart_break_tx_chk.sv
module uart_break_tx_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [2:0]    bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          brk_now,
  input logic          brk_act,
  input logic          bit_tick,
  input logic [15:0]   divisor,
  input logic [CW-1:0] q_count,
  input logic [CW-1:0] q_cap,
  input logic          tx_empty,
  input logic          txd
);
  assert_zero_div_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == 16'd0) |-> !bit_tick);

  assert_break_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    brk_act |-> (txd == 1'b0));

  assert_break_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3 && bus_wdata[6] && !brk_now) |=> tx_empty);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= q_cap);

  assert_empty_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty == (q_count == '0));

  assert_edge_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(bit_tick));
endmodule

bind uart_break_tx uart_break_tx_chk #(.CW($clog2(DEPTH + 1))) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .brk_now(lctl.brk), .brk_act(brk_act),
  .bit_tick(bit_tick), .divisor(divisor), .q_count(q_count), .q_cap(q_cap),
  .tx_empty(tx_empty), .txd(txd)
);

// File: tb/uart_break_tx_tb.sv
module uart_break_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       tx_empty, txd;

  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  uart_break_tx #(.DEPTH(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tx_empty(tx_empty), .txd(txd)
  );

  // behavioural reference model
  int         m_cnt, m_sub, m_div;
  logic [7:0] m_lc;
  bit         m_fen, m_brk, m_tx;
  byte        m_q[$];
  bit         m_bits[$];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sub = 0; m_div = 0; m_lc = 0; m_fen = 0;
      m_brk = 0; m_tx = 1; m_q.delete(); m_bits.delete();
    end else begin
      bit tick;
      int old_sz;
      old_sz = m_q.size();
      tick = (m_div != 0) && (m_cnt >= m_div - 1) && (m_sub == 15);
      if (m_div == 0) begin m_cnt = 0; m_sub = 0; end
      else if (m_cnt >= m_div - 1) begin m_cnt = 0; m_sub = (m_sub + 1) % 16; end
      else m_cnt++;
      if (tick) begin
        if (m_lc[6]) begin m_brk = 1; m_tx = 0; m_bits.delete(); end
        else if (m_brk) begin m_brk = 0; m_tx = 1; end
        else if (m_bits.size() != 0) m_tx = m_bits.pop_front();
        else if (m_q.size() != 0) begin
          byte d; int nd; int ones;
          d = m_q.pop_front(); nd = 5 + m_lc[1:0]; ones = 0;
          m_tx = 0;
          for (int i = 0; i < nd; i++) begin m_bits.push_back(d[i]); ones += d[i]; end
          if (m_lc[3]) m_bits.push_back(((ones % 2) == 1) ^ !m_lc[4] ^ m_lc[5]);
          m_bits.push_back(1);
          if (m_lc[2]) m_bits.push_back(1);
        end else m_tx = 1;
      end
      if (bus_wr) begin
        case (bus_addr)
          3'd0: if (m_lc[7]) m_div = (m_div & 16'hFF00) | bus_wdata;
                else if (old_sz < (m_fen ? 16 : 1)) m_q.push_back(bus_wdata);
          3'd1: if (m_lc[7]) m_div = (m_div & 16'h00FF) | (int'(bus_wdata) << 8);
          3'd2: begin m_fen = bus_wdata[0]; m_q.delete(); end
          3'd3: begin if (bus_wdata[6] && !m_lc[6]) m_q.delete(); m_lc = bus_wdata; end
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison of the line (R2, R4, R6, R7) and the empty flag (R10)
  always @(negedge clk) if (rst_n) begin
    check("R2 txd", txd, m_tx);
    check("R10 tx_empty", tx_empty, m_q.size() == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (m_q.size() != 0 || m_bits.size() != 0) @(negedge clk);
    idle(40);
  endtask

  initial begin
    logic [7:0] r;
    idle(4); rst_n = 1'b1; idle(2);
    check("R10 reset empty", tx_empty, 1);
    check("R2 reset idle line", txd, 1);
    rd(3'd3, r); check("R9 line control reset", r, 8'h00);

    wr(3'd3, 8'h80); wr(3'd0, 8'h01); wr(3'd1, 8'h00);
    rd(3'd0, r); check("R1 divisor low readback", r, 8'h01);
    rd(3'd1, r); check("R1 divisor high readback", r, 8'h00);
    wr(3'd3, 8'h03);
    rd(3'd3, r); check("R9 line control readback", r, 8'h03);
    rd(3'd0, r); check("R1 data read without access bit", r, 8'h00);

    // R8 FIFO on, R2 8N1 back to back
    wr(3'd2, 8'h01);
    wr(3'd0, 8'h55); wr(3'd0, 8'hA3); wr(3'd0, 8'h0F);
    rd(3'd5, r); check("R10 status not empty", r[0], 0);
    drain();
    rd(3'd5, r); check("R10 status empty", r[0], 1);

    // R2 7 bits, even parity, two stops
    wr(3'd3, 8'h1E); wr(3'd0, 8'h35); wr(3'd0, 8'hC6); drain();
    // R7 odd parity with forced error; R2 5 bits
    wr(3'd3, 8'h2B); wr(3'd0, 8'h81); drain();
    wr(3'd3, 8'h38); wr(3'd0, 8'h13); drain();

    // R4 R5 R6 break
    wr(3'd3, 8'h03);
    for (int i = 0; i < 4; i++) wr(3'd0, 8'h30 + 8'(i));
    idle(50);
    wr(3'd3, 8'h43);
    check("R5 queue emptied by break", tx_empty, 1);
    idle(40);
    check("R4 line held low", txd, 0);
    wr(3'd0, 8'h5A);
    idle(100);
    check("R6 byte kept during break", tx_empty, 0);
    check("R4 still low", txd, 0);
    wr(3'd3, 8'h03);
    drain();

    // R3 divisor zero freezes; R8 single holding register drops extras
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h80); wr(3'd0, 8'h00); wr(3'd3, 8'h03);
    wr(3'd0, 8'h11); wr(3'd0, 8'h22);
    idle(100);
    check("R3 line frozen at zero divisor", txd, 1);
    check("R3 byte still held", tx_empty, 0);
    wr(3'd3, 8'h80); wr(3'd0, 8'h02); wr(3'd3, 8'h03);
    drain();
    check("R8 only one frame sent", tx_empty, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule